// File: doc/BRIEF.md
# Multi-lane SPI master shift engine

This block is the byte engine of a serial peripheral master. A host hands it one byte at a time over a valid/ready handshake. The engine then produces the serial clock, drives the data lanes and samples them, and returns the received byte with a one-cycle done pulse. The serial clock runs at a fixed fraction of the system clock, set by a parameter. Clock polarity and clock phase are read from two inputs at the moment a byte is accepted, so all four clock modes are available from one transfer to the next.

A two-bit lane mode, also taken at accept time, selects how the data pins are used:
- **Standard (00):** a full-duplex transfer, sending on lane 0 while receiving on lane 1.
- **Three-wire (01):** a half-duplex transfer on lane 0 alone.
- **Quad (10):** a half-duplex transfer that moves a nibble per serial clock on lanes 3..0.

In the two half-duplex modes a direction flag decides whether the byte is written or read. Code 11 is reserved and behaves as standard. Chip selection, pad tristate cells and any further lane widths are left to the surrounding logic. The engine presents per-lane output values and output enables for the pads.

The controller has three states. ST_IDLE waits for a byte. The transition ST_IDLE→ST_RUN happens on accept. ST_RUN toggles the serial clock. The transition ST_RUN→ST_DONE happens on the final serial clock edge. ST_DONE always returns to ST_IDLE after one cycle.

Top module: `spi_lane_master`

## Requirements
- R1: While no byte is in flight, `sck` equals the `cpol` input sampled one system clock earlier; reset sets it to 0.
- R2: `tx_ready` is high only in ST_IDLE. A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_valid` raised while busy starts nothing and leaves the byte in flight unchanged.
- R3: Each half period of `sck` lasts HALF_DIV system clocks, and the first `sck` edge comes HALF_DIV clocks after the accept edge. A byte takes 8 `sck` periods in standard and three-wire modes and 2 in quad mode, so `rx_valid` is seen 16*HALF_DIV or 4*HALF_DIV clocks after the accept edge.
- R4: With `cpha`=0 the lanes are sampled on every leading `sck` edge (the edge leaving the idle level), and the first output bit is valid from the accept edge. With `cpha`=1 they are sampled on every trailing edge, and outputs change only on leading edges after the first. Outputs never change on a sampling edge.
- R5: In standard mode (`lane_mode`=00, and the reserved 11), the engine transmits on `dq_out[0]` and receives from `dq_in[1]` in the same transfer. `dq_oe` is 0001 while busy, and `rd_dir` has no effect.
- R6: In three-wire mode (01), lane 0 carries the data. With `rd_dir`=0 the engine drives lane 0 (`dq_oe`=0001) and `rx_byte` reads 00. With `rd_dir`=1 `dq_oe` is 0000 for the whole byte and `dq_in[0]` is sampled.
- R7: In quad mode (10), each sampling edge moves a nibble, with bit 3 of the nibble on lane 3. A write drives `dq_oe`=1111 for the whole byte, and `rx_byte` reads 00. A read keeps `dq_oe`=0000 for the whole byte and samples `dq_in[3:0]`.
- R8: Bits move most significant first; in quad mode the upper nibble moves before the lower one.
- R9: `rx_valid` is high for exactly one system clock, in the cycle after the final `sck` edge, with `sck` back at the idle level. `rx_byte` then holds its value until the next accept.
- R10: Reset, even during a transfer, returns the engine to ST_IDLE with `tx_ready`=1, `rx_valid`=0, `dq_oe`=0000, `sck`=0 and `rx_byte`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpol | input | 1 | Serial clock idle level, taken at accept |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lane_mode | input | 2 | 00 standard, 01 three-wire, 10 quad, 11 as standard |
| tx_valid | input | 1 | Host offers a byte |
| tx_ready | output | 1 | Engine idle and able to accept |
| tx_byte | input | 8 | Byte to send |
| rd_dir | input | 1 | Half-duplex modes: 1 read, 0 write |
| rx_valid | output | 1 | One-cycle done pulse |
| rx_byte | output | 8 | Received byte |
| sck | output | 1 | Serial clock |
| dq_out | output | 4 | Per-lane output values |
| dq_oe | output | 4 | Per-lane output enables |
| dq_in | input | 4 | Per-lane sampled inputs |

## Verification
A bench-side peripheral model answers every transfer. It drives inverted copies of its bit onto the lanes a mode should ignore. A wrong-lane or wrong-edge choice therefore changes the received byte rather than hiding behind it. The stimulus table covers each of the four clock modes in standard operation, and three-wire and quad transfers in both directions under mixed modes. It also includes a standard transfer with the read flag set and one with the reserved lane code. Asymmetric byte pairs separate bit order, nibble order and a missing or extra shift. Directed tests cover the reset state, the idle clock level following polarity, a byte offered while busy, and reset in mid-transfer.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;

    typedef enum logic [1:0] {
        LM_STD  = 2'b00,
        LM_3W   = 2'b01,
        LM_QUAD = 2'b10,
        LM_RSVD = 2'b11
    } lane_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } xfer_state_e;

endpackage

// File: rtl/spi_lane_ticker.sv
module spi_lane_ticker #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
    import spi_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  lane_mode_e        mode,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic [LANES-1:0]  dq_in,
    output logic [LANES-1:0]  dq_out,
    output logic [BYTE_W-1:0] rx_byte
);

    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic              quad;

    assign quad = (mode == LM_QUAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= load_byte;
        end else if (shift_en) begin
            tx_sh <= quad ? {tx_sh[BYTE_W-LANES-1:0], {LANES{1'b0}}}
                          : {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh <= '0;
        end else if (load) begin
            rx_sh <= '0;
        end else if (sample_en && capture_en) begin
            unique case (mode)
                LM_QUAD: rx_sh <= {rx_sh[BYTE_W-LANES-1:0], dq_in};
                LM_3W:   rx_sh <= {rx_sh[BYTE_W-2:0], dq_in[0]};
                default: rx_sh <= {rx_sh[BYTE_W-2:0], dq_in[1]};
            endcase
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign dq_out[g] = quad ? tx_sh[BYTE_W-LANES+g] : tx_sh[BYTE_W-1];
        end else begin : g_upper
            assign dq_out[g] = quad & tx_sh[BYTE_W-LANES+g];
        end
    end

    assign rx_byte = rx_sh;

    AST_TX_HELD_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !load) |=> $stable(tx_sh)); // R4

endmodule

// File: rtl/spi_lane_master.sv
module spi_lane_master
    import spi_lane_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [1:0]        lane_mode,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              rd_dir,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sck,
    output logic [LANES-1:0]  dq_out,
    output logic [LANES-1:0]  dq_oe,
    input  logic [LANES-1:0]  dq_in
);

    localparam int EW          = $clog2(2 * BYTE_W);
    localparam int EDGES_WIDE  = 2 * BYTE_W;
    localparam int EDGES_QUAD  = 2 * BYTE_W / LANES;

    xfer_state_e   state, nxt;
    lane_mode_e    mode_l;
    logic          cpol_l, cpha_l, rd_l;
    logic          sck_q;
    logic [EW-1:0] edge_cnt;
    logic [EW-1:0] last_edge;
    logic          tick, accept, leading, sample_now, drive_now;
    logic          half_duplex, rd_active, capture_en;

    spi_lane_ticker #(.HALF_DIV(HALF_DIV)) u_ticker (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_RUN),
        .tick  (tick)
    );

    assign accept      = (state == ST_IDLE) && tx_valid;
    assign half_duplex = (mode_l == LM_3W) || (mode_l == LM_QUAD);
    assign rd_active   = half_duplex && rd_l;
    assign capture_en  = !half_duplex || rd_l;
    assign last_edge   = (mode_l == LM_QUAD) ? EW'(EDGES_QUAD - 1) : EW'(EDGES_WIDE - 1);
    assign leading     = ~edge_cnt[0];
    assign sample_now  = tick && (leading ^ cpha_l);
    assign drive_now   = tick && !(leading ^ cpha_l) && (edge_cnt != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (tx_valid) nxt = ST_RUN;
            ST_RUN:  if (tick && edge_cnt == last_edge) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // transfer context, serial clock and edge index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_l   <= LM_STD;
            cpol_l   <= 1'b0;
            cpha_l   <= 1'b0;
            rd_l     <= 1'b0;
            sck_q    <= 1'b0;
            edge_cnt <= '0;
        end else begin
            if (state == ST_IDLE) begin
                sck_q <= cpol;
            end else if (state == ST_RUN && tick) begin
                sck_q <= ~sck_q;
            end
            if (accept) begin
                mode_l   <= (lane_mode == LM_RSVD) ? LM_STD : lane_mode_e'(lane_mode);
                cpol_l   <= cpol;
                cpha_l   <= cpha;
                rd_l     <= rd_dir;
                edge_cnt <= '0;
            end else if (tick) begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_ready = (state == ST_IDLE);
        rx_valid = (state == ST_DONE);
        dq_oe    = '0;
        unique case (state)
            ST_RUN: begin
                if (!rd_active) begin
                    dq_oe = (mode_l == LM_QUAD) ? {LANES{1'b1}} : LANES'(1);
                end
            end
            default: dq_oe = '0;
        endcase
    end

    assign sck = sck_q;

    spi_lane_shifter u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_byte  (tx_byte),
        .mode       (mode_l),
        .capture_en (capture_en),
        .shift_en   (drive_now),
        .sample_en  (sample_now),
        .dq_in      (dq_in),
        .dq_out     (dq_out),
        .rx_byte    (rx_byte)
    );

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state) == ST_IDLE) |-> sck == $past(cpol)); // R1

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready); // R2

    AST_SCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !tick) |=> $stable(sck)); // R3

    AST_READ_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && rd_active) |-> dq_oe == '0); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R9

    AST_DONE_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> sck == cpol_l); // R9

    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !tx_valid) |=> $stable(rx_byte)); // R9

endmodule

// File: tb/spi_lane_master_test.sv
module spi_lane_master_test;
    import spi_lane_pkg::*;

    localparam int HALF = 2;
    localparam int NVEC = 13;

    // {lane_mode[1:0], cpol, cpha, rd_dir, master byte[7:0], peripheral byte[7:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {2'b00, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
        {2'b00, 1'b0, 1'b1, 1'b0, 8'h81, 8'h7E},
        {2'b00, 1'b1, 1'b0, 1'b0, 8'h5A, 8'hC3},
        {2'b00, 1'b1, 1'b1, 1'b0, 8'hF0, 8'h0F},
        {2'b00, 1'b0, 1'b0, 1'b1, 8'h96, 8'h69},
        {2'b11, 1'b1, 1'b1, 1'b0, 8'h12, 8'hED},
        {2'b01, 1'b0, 1'b0, 1'b0, 8'hB4, 8'h4B},
        {2'b01, 1'b1, 1'b1, 1'b1, 8'h00, 8'hD2},
        {2'b01, 1'b0, 1'b1, 1'b1, 8'h3E, 8'h8C},
        {2'b10, 1'b0, 1'b0, 1'b0, 8'hC6, 8'h5E},
        {2'b10, 1'b1, 1'b0, 1'b1, 8'h11, 8'hA7},
        {2'b10, 1'b0, 1'b1, 1'b1, 8'h9B, 8'h2D},
        {2'b10, 1'b1, 1'b1, 1'b0, 8'h74, 8'hE1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0, cpha = 1'b0, rd_dir = 1'b0, tx_valid = 1'b0;
    logic [1:0] lane_mode = 2'b00;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_ready, rx_valid, sck;
    logic [7:0] rx_byte;
    logic [3:0] dq_out, dq_oe, dq_in;

    int checks = 0;
    int errors = 0;

    // peripheral model state
    logic       slv_act = 1'b0;
    logic       slv_quad = 1'b0, slv_3w = 1'b0, slv_cpol = 1'b0, slv_cpha = 1'b0;
    logic [7:0] slv_sh = 8'h00, slv_rx = 8'h00;
    int         slv_edges = 0;

    always #4 clk = ~clk;

    spi_lane_master #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .lane_mode(lane_mode),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte), .rd_dir(rd_dir),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .sck(sck), .dq_out(dq_out),
        .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // ignored lanes carry the inverted bit so a wrong-lane pick is visible
    assign dq_in = slv_quad ? slv_sh[7:4]
                 : slv_3w   ? {~slv_sh[7], ~slv_sh[7], ~slv_sh[7], slv_sh[7]}
                 :            {~slv_sh[7], ~slv_sh[7], slv_sh[7], ~slv_sh[7]};

    always @(posedge sck or negedge sck) begin
        if (slv_act) begin
            if ((sck != slv_cpol) ^ slv_cpha) begin
                slv_rx = slv_quad ? {slv_rx[3:0], dq_out} : {slv_rx[6:0], dq_out[0]};
            end else if (slv_edges != 0) begin
                slv_sh = slv_quad ? {slv_sh[3:0], 4'h0} : {slv_sh[6:0], 1'b0};
            end
            slv_edges = slv_edges + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [20:0] v);
        logic [1:0] m;
        logic       pol, pha, dir, hd, quad;
        logic [7:0] mtx, stx, exp_rx;
        logic [3:0] oe_exp;
        int         edges, cyc, oe_err, rdy_err;
        string      tag;
        {m, pol, pha, dir, mtx, stx} = v;
        quad   = (m == 2'b10);
        hd     = (m == 2'b01) || quad;
        edges  = quad ? 4 : 16;
        exp_rx = (!hd || dir) ? stx : 8'h00;
        oe_exp = (hd && dir) ? 4'b0000 : (quad ? 4'b1111 : 4'b0001);
        tag    = quad ? "R4 R7 R8" : (hd ? "R4 R6 R8" : "R4 R5 R8");

        @(negedge clk);
        cpol = pol; cpha = pha;
        repeat (2) @(negedge clk);
        chk(sck == pol, "R1", "idle sck before transfer", sck, pol);
        slv_quad = quad; slv_3w = (m == 2'b01); slv_cpol = pol; slv_cpha = pha;
        slv_sh = stx; slv_rx = 8'h00; slv_edges = 0; slv_act = 1'b1;
        lane_mode = m; rd_dir = dir; tx_byte = mtx; tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_byte = ~mtx;   // stray offer while busy (R2)
        cyc = 1; oe_err = 0; rdy_err = 0;
        while (rx_valid !== 1'b1 && cyc < 1000) begin
            if (dq_oe !== oe_exp) oe_err++;
            if (tx_ready !== 1'b0) rdy_err++;
            @(negedge clk);
            cyc++;
        end
        tx_valid = 1'b0;
        chk(cyc == edges * HALF + 1, "R3", "clocks to done", cyc, edges * HALF + 1);
        chk(oe_err == 0, tag, "output enable mismatches", oe_err, 0);
        chk(rdy_err == 0, "R2", "ready while busy", rdy_err, 0);
        chk(slv_edges == edges, "R3", "sck edges", slv_edges, edges);
        chk(sck == pol, "R9", "sck idle at done", sck, pol);
        chk(rx_byte == exp_rx, tag, "received byte", rx_byte, exp_rx);
        if (!hd || !dir) chk(slv_rx == mtx, tag, "peripheral got", slv_rx, mtx);
        slv_act = 1'b0;
        @(negedge clk);
        chk(rx_valid == 1'b0, "R9", "done pulse width", rx_valid, 0);
        chk(tx_ready == 1'b1, "R2", "ready after done", tx_ready, 1);
        repeat (3) @(negedge clk);
        chk(tx_ready == 1'b1 && sck == pol, "R2", "stray offer ignored", {tx_ready, sck}, {1'b1, pol});
        chk(rx_byte == exp_rx, "R9", "rx byte held", rx_byte, exp_rx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_ready == 1'b1 && rx_valid == 1'b0, "R10", "handshake in reset", {tx_ready, rx_valid}, 2'b10);
        chk(sck == 1'b0 && dq_oe == 4'h0, "R10", "pins in reset", {sck, dq_oe}, 0);
        chk(rx_byte == 8'h00, "R10", "rx byte in reset", rx_byte, 0);
        rst_n = 1'b1;

        cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(sck == 1'b1, "R1", "idle sck follows cpol high", sck, 1);
        cpol = 1'b0;
        repeat (2) @(negedge clk);
        chk(sck == 1'b0, "R1", "idle sck follows cpol low", sck, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_xfer(VEC[i]);
        end

        // reset in mid-transfer
        @(negedge clk);
        cpol = 1'b1; cpha = 1'b0; lane_mode = 2'b10; rd_dir = 1'b0; tx_byte = 8'hC3;
        repeat (2) @(negedge clk);
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(dq_oe == 4'hF, "R7", "quad write enables", dq_oe, 4'hF);
        rst_n = 1'b0;
        #1;
        chk(sck == 1'b0 && dq_oe == 4'h0, "R10", "pins after mid reset", {sck, dq_oe}, 0);
        chk(tx_ready == 1'b1 && rx_valid == 1'b0, "R10", "handshake after mid reset", {tx_ready, rx_valid}, 2'b10);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sck == 1'b1 && rx_byte == 8'h00, "R10", "idle after mid reset", {sck, rx_byte}, {1'b1, 8'h00});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule